// File: doc/BRIEF.md
# Level-Mapped Priority Interrupt Controller

This block gathers eight level-sensitive interrupt request lines and presents them to a processor as sixteen interrupt-priority-level lines. Each request line is tied by a fixed, non-linear table to one priority level. Two request positions map to level 0 and are dead: they never become pending and never reach an output. Every output line is the OR of the pending requests that map to it. A registered binary output gives the number of the highest priority line that is asserted.

A single byte-wide control register sits on a minimal write/read port with no address decoding. Every access reaches that register, so any offset or access width in the surrounding bus lands on it. Bit 0 of the register is a master enable. Bit 6 cannot be set. Request lines pass through a two-stage synchroniser before they are captured as pending. The outputs are recomputed on every clock, so a change in a request or in the register reaches the priority lines after a fixed number of cycles.

Top module: `pil_irq_ctrl`

## Requirements
- R1: Request line i, held high with the enable set, drives priority line M(i) high, where M maps 0..7 to 0, 1, 4, 6, 8, 10, 0, 14 (line 1 to level 1, line 2 to 4, line 3 to 6, line 4 to 8, line 5 to 10, line 7 to 14).
- R2: Request lines 0 and 6 (mapped level 0) have no effect on any output, and priority line 0 is never high.
- R3: Pending state is level-sensitive. When a request line goes low, its priority line drops with the same latency as it rose, and nothing is latched.
- R4: A priority line is high while at least one pending request mapped to it is high. Requests that map to different levels drive their lines independently.
- R5: A write stores the write data ANDed with 0xBF. The read data always shows the stored byte, so bit 6 reads 0, and a write is visible on the read data after the clock edge that takes it.
- R6: Synchronous active-high reset sets the register to 0x01, clears all pending and synchroniser state, and drives all priority lines and the encoded output to 0.
- R7: While register bit 0 is 0, all priority lines are low and the encoded output is 0. Pending state keeps following the requests, so setting bit 0 again restores the lines for the requests that are currently high.
- R8: The encoded output gives the index of the highest asserted priority line, or 0 when none is asserted, and changes in the same cycle as the lines.
- R9: A request change is visible on the priority outputs after the fourth rising edge that follows it (two synchroniser stages, pending capture, output register). A register write affects the outputs on the rising edge after the one that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC (8) | Level-sensitive interrupt request lines, asynchronous |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Stored register byte |
| pil_o | output | NUM_PIL (16) | One-hot-per-level priority lines |
| pil_top_o | output | PIL_W (4) | Index of the highest asserted priority line, 0 if none |

## Verification
The bench builds the block with its default parameters: eight request lines, sixteen priority lines and two synchroniser stages. These are the only values for which the fixed mapping table is fully used, so every live and dead request position, the exact four-edge request latency and the one-edge register latency can be observed. Patterns cover single requests, overlapping requests across several levels, request changes while the enable is off, and writes that try to set bit 6.

// File: rtl/pil_irq_pkg.sv
package pil_irq_pkg;

    localparam int SRC_N      = 8;
    localparam int PIL_N      = 16;
    localparam int PIL_NUM_W  = $clog2(PIL_N);
    localparam int CTRL_W     = 8;
    localparam int EN_BIT     = 0;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h01;
    localparam logic [CTRL_W-1:0] CTRL_KEEP  = 8'hBF;

    typedef logic [PIL_NUM_W-1:0] pil_num_t;

    typedef struct packed {
        logic [PIL_N-1:0] lines;
        pil_num_t         top;
    } pil_out_t;

    // Fixed request-to-level table; unlisted positions resolve to level 0.
    function automatic pil_num_t src_level(input int idx);
        pil_num_t lvl;
        case (idx)
            1:       lvl = pil_num_t'(1);
            2:       lvl = pil_num_t'(4);
            3:       lvl = pil_num_t'(6);
            4:       lvl = pil_num_t'(8);
            5:       lvl = pil_num_t'(10);
            7:       lvl = pil_num_t'(14);
            default: lvl = '0;
        endcase
        return lvl;
    endfunction

    function automatic logic src_is_live(input int idx);
        return src_level(idx) != '0;
    endfunction

endpackage

// File: rtl/pil_sync.sv
module pil_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= '0;
        else     chain_q[0] <= d_i;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= '0;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pil_capture.sv
module pil_capture
    import pil_irq_pkg::*;
#(
    parameter int W = SRC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sync_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] live_mask;

    always_comb begin
        for (int i = 0; i < W; i++) live_mask[i] = src_is_live(i);
    end

    always_ff @(posedge clk) begin
        if (rst) pend_o <= '0;
        else     pend_o <= sync_i & live_mask;
    end
endmodule

// File: rtl/pil_map_out.sv
module pil_map_out
    import pil_irq_pkg::*;
#(
    parameter int NSRC  = SRC_N,
    parameter int NPIL  = PIL_N,
    parameter int NUM_W = $clog2(NPIL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  pend_i,
    input  logic             enable_i,
    output logic [NPIL-1:0]  lines_o,
    output logic [NUM_W-1:0] top_o
);
    logic [NPIL-1:0]  lines_n;
    logic [NUM_W-1:0] top_n;

    always_comb begin
        lines_n = '0;
        for (int p = 0; p < NPIL; p++) begin
            for (int i = 0; i < NSRC; i++) begin
                if (pend_i[i] && src_is_live(i) &&
                    (int'(src_level(i)) == p))
                    lines_n[p] = 1'b1;
            end
        end
        if (!enable_i) lines_n = '0;
    end

    always_comb begin
        top_n = '0;
        for (int p = 0; p < NPIL; p++) begin
            if (lines_n[p]) top_n = NUM_W'(p);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_o <= '0;
            top_o   <= '0;
        end else begin
            lines_o <= lines_n;
            top_o   <= top_n;
        end
    end
endmodule

// File: rtl/pil_irq_ctrl.sv
module pil_irq_ctrl
    import pil_irq_pkg::*;
#(
    parameter int NUM_SRC     = SRC_N,
    parameter int NUM_PIL     = PIL_N,
    parameter int SYNC_STAGES = 2,
    localparam int PIL_W      = $clog2(NUM_PIL)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               reg_wr_i,
    input  logic [CTRL_W-1:0]  reg_wdata_i,
    output logic [CTRL_W-1:0]  reg_rdata_o,
    output logic [NUM_PIL-1:0] pil_o,
    output logic [PIL_W-1:0]   pil_top_o
);
    logic [NUM_SRC-1:0] sync_w;
    logic [NUM_SRC-1:0] pend_w;
    logic [CTRL_W-1:0]  ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)           ctrl_q <= CTRL_RESET;
        else if (reg_wr_i) ctrl_q <= reg_wdata_i & CTRL_KEEP;
    end

    assign reg_rdata_o = ctrl_q;

    pil_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (src_i),
        .q_o (sync_w)
    );

    pil_capture #(.W(NUM_SRC)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync_w),
        .pend_o (pend_w)
    );

    pil_map_out #(.NSRC(NUM_SRC), .NPIL(NUM_PIL), .NUM_W(PIL_W)) u_map (
        .clk      (clk),
        .rst      (rst),
        .pend_i   (pend_w),
        .enable_i (ctrl_q[EN_BIT]),
        .lines_o  (pil_o),
        .top_o    (pil_top_o)
    );
endmodule

// File: rtl/pil_irq_ctrl_chk.sv
module pil_irq_ctrl_chk #(
    parameter int NUM_PIL = 16,
    parameter int PIL_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr_i,
    input logic [7:0]         reg_wdata_i,
    input logic [7:0]         reg_rdata_o,
    input logic [NUM_PIL-1:0] pil_o,
    input logic [PIL_W-1:0]   pil_top_o
);
    // R6
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (reg_rdata_o == 8'h01 && pil_o == '0 && pil_top_o == '0));

    // R2
    dead_level_chk: assert property (@(posedge clk) disable iff (rst)
        !pil_o[0]);

    // R5
    write_mask_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_i |=> (reg_rdata_o == ($past(reg_wdata_i) & 8'hBF)));

    // R7
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata_o[0] |=> (pil_o == '0 && pil_top_o == '0));

    // R8
    top_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (pil_o == '0) |-> (pil_top_o == '0));

    // R8
    top_highest_chk: assert property (@(posedge clk) disable iff (rst)
        (pil_o != '0) |-> ((pil_o >> pil_top_o) == {{(NUM_PIL-1){1'b0}}, 1'b1}));
endmodule

bind pil_irq_ctrl pil_irq_ctrl_chk #(.NUM_PIL(NUM_PIL), .PIL_W(PIL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .pil_o       (pil_o),
    .pil_top_o   (pil_top_o)
);

// File: tb/test_pil_irq_ctrl.sv
`timescale 1ns/1ps
module test_pil_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  src = '0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] pil;
    logic [3:0]  top;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R6";

    always #10 clk = ~clk;

    pil_irq_ctrl i_pil_irq_ctrl (
        .clk(clk), .rst(rst), .src_i(src), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pil_o(pil), .pil_top_o(top)
    );

    // Reference model: requirement table, a delay queue for requests
    int lvl_tab[8] = '{0, 1, 4, 6, 8, 10, 0, 14};
    logic [7:0]  req_q[$];
    logic [7:0]  m_ctrl = 8'h01;
    logic [15:0] m_pil = '0;
    logic [3:0]  m_top = '0;

    function automatic logic [15:0] levels_of(logic [7:0] pend, logic [7:0] ctrl);
        logic [15:0] r = '0;
        for (int i = 0; i < 8; i++)
            if (pend[i] && lvl_tab[i] != 0) r[lvl_tab[i]] = 1'b1;
        if (!ctrl[0]) r = '0;
        return r;
    endfunction

    function automatic logic [3:0] highest(logic [15:0] v);
        logic [3:0] h = '0;
        for (int p = 0; p < 16; p++) if (v[p]) h = 4'(p);
        return h;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            req_q = '{8'h00, 8'h00, 8'h00};
            m_ctrl = 8'h01;
            m_pil = '0;
            m_top = '0;
        end else begin
            // req_q[0] is the pending value captured on the previous edge
            m_pil = levels_of(req_q[0], m_ctrl);
            m_top = highest(m_pil);
            void'(req_q.pop_front());
            req_q.push_back(src);
            if (wr) m_ctrl = wdata & 8'hBF;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (pil !== m_pil || top !== m_top || rdata !== m_ctrl) begin
                errors++;
                $display("FAIL %s per-cycle: pil=%h top=%0d rd=%h exp pil=%h top=%0d rd=%h",
                         cur_req, pil, top, rdata, m_pil, m_top, m_ctrl);
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(logic [7:0] v);
        @(negedge clk);
        wr = 1'b1; wdata = v;
        @(negedge clk);
        wr = 1'b0;
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        cycles(1);
        cur_req = "R6";
        check("R6", {24'd0, rdata}, 32'h01);
        check("R6", {16'd0, pil}, 32'h0);
        check("R6", {28'd0, top}, 32'h0);

        // Single request at a time: mapping, dead positions, release
        for (int i = 0; i < 8; i++) begin
            cur_req = (lvl_tab[i] == 0) ? "R2" : "R1";
            src = 8'(1 << i);
            cycles(6);
            if (lvl_tab[i] == 0) check("R2", {16'd0, pil}, 32'h0);
            else begin
                check("R1", {16'd0, pil}, 32'(1 << lvl_tab[i]));
                check("R8", {28'd0, top}, 32'(lvl_tab[i]));
            end
            cur_req = "R3";
            src = '0;
            cycles(6);
            check("R3", {16'd0, pil}, 32'h0);
        end

        // Exact latency of a request edge
        cur_req = "R9";
        @(negedge clk);
        src = 8'h80;
        cycles(3);
        check("R9", {16'd0, pil}, 32'h0);
        cycles(1);
        check("R9", {16'd0, pil}, 32'h4000);
        src = 8'h00;
        cycles(3);
        check("R3", {16'd0, pil}, 32'h4000);
        cycles(1);
        check("R3", {16'd0, pil}, 32'h0);

        // Overlapping requests
        cur_req = "R4";
        src = 8'h3C;
        cycles(6);
        check("R4", {16'd0, pil}, 32'h0550);
        check("R8", {28'd0, top}, 32'd10);
        src = 8'hFF;
        cycles(6);
        check("R4", {16'd0, pil}, 32'h4552);
        check("R8", {28'd0, top}, 32'd14);
        check("R2", {31'd0, pil[0]}, 32'h0);
        src = 8'h43;
        cycles(6);
        check("R4", {16'd0, pil}, 32'h0002);
        check("R8", {28'd0, top}, 32'd1);

        // Register writes and masking
        cur_req = "R5";
        reg_write(8'hFF);
        check("R5", {24'd0, rdata}, 32'hBF);
        reg_write(8'h41);
        check("R5", {24'd0, rdata}, 32'h01);

        // Enable gating; pending keeps tracking while disabled
        cur_req = "R7";
        src = 8'h3C;
        cycles(6);
        reg_write(8'h40);
        check("R5", {24'd0, rdata}, 32'h00);
        check("R9", {16'd0, pil}, 32'h0550);
        cycles(1);
        check("R7", {16'd0, pil}, 32'h0);
        check("R7", {28'd0, top}, 32'h0);
        src = 8'h80;
        cycles(6);
        check("R7", {16'd0, pil}, 32'h0);
        reg_write(8'h01);
        check("R9", {16'd0, pil}, 32'h0);
        cycles(1);
        check("R7", {16'd0, pil}, 32'h4000);
        check("R8", {28'd0, top}, 32'd14);

        // Reset mid-activity
        cur_req = "R6";
        reg_write(8'h8D);
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
        src = '0;
        cycles(1);
        check("R6", {24'd0, rdata}, 32'h01);
        check("R6", {16'd0, pil}, 32'h0);
        cycles(6);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule